// File: doc/BRIEF.md
# Single-Accumulator Multicycle Processor Core

This block is a small multicycle processor built around one 16-bit accumulator, a program counter and an instruction register. Programs and data share a word-addressed store of 4096 sixteen-bit words that sits inside the block as a synchronous array. Each instruction is one word: a 4-bit operation code above a 12-bit operand address. The instruction set moves words between memory and the accumulator, does wrapping arithmetic, tests the accumulator for zero or sign, takes words in from a valid/ready input stream, sends words out on a valid/ready output stream, shifts, complements and forms the exclusive-or of two words.

Before a run, the surrounding logic or a testbench holds reset low and fills the store through the preload port. Releasing reset starts execution at address 0. The core runs until it meets a halt or the undefined code 15. It then raises `halted` and stays quiet until the next reset. Comparing two words takes three instructions: load one, exclusive-or the other, then jump if the accumulator is zero.

Top module: `acc_core`

## Requirements
- R1: While reset is held and directly after it, `halted`, `in_ready` and `out_valid` are 0. Execution begins with the word at address 0.
- R2: Instruction bits 15:12 select the operation and bits 11:0 give the operand address. Codes are 0 halt, 1 load (clear-and-add), 2 store, 3 add, 4 subtract, 5 multiply, 6 divide, 7 jump, 8 jump-if-negative, 9 jump-if-zero, 10 input, 11 output, 12 shift right, 13 complement, 14 exclusive-or. After each fetch the program counter moves to the next address unless a jump is taken.
- R3: Code 1 replaces the accumulator with the addressed word. Code 2 writes the accumulator into the addressed word.
- R4: Codes 3, 4 and 5 combine the accumulator with the addressed word as sum, difference (accumulator minus word) and product. Only the low 16 bits of each result are kept.
- R5: Code 6 leaves the unsigned quotient of the accumulator divided by the addressed word. A zero divisor leaves 16'hFFFF.
- R6: Code 12 shifts the accumulator right by one bit and fills bit 15 with 0. Code 13 inverts every accumulator bit. Neither one depends on its address field.
- R7: Code 14 leaves the bitwise exclusive-or of the accumulator and the addressed word. The result is zero exactly when the two words are equal.
- R8: Code 7 always jumps to its address. Code 9 jumps when the accumulator is 0. Code 8 jumps when accumulator bit 15 is 1. A jump that is not taken continues with the next word.
- R9: Code 10 holds `in_ready` high and waits, however long it takes, for `in_valid`. It then stores `in_data` at the addressed word.
- R10: Code 11 raises `out_valid` with the addressed word on `out_data`. Both stay unchanged until `out_ready` is 1. No more than one of `in_ready` and `out_valid` is high at a time.
- R11: Code 0 and code 15 both stop the core. `halted` then stays 1 until reset, and the core raises no further port activity.
- R12: The preload port writes memory only while reset is held. A preload write while the core runs has no effect on the program.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside the block on a clock edge |
| pre_we | input | 1 | Preload write strobe, honoured only in reset |
| pre_addr | input | 12 | Preload word address |
| pre_data | input | 16 | Preload word |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Core is waiting in an input instruction |
| in_data | input | 16 | Input word |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Receiver accepts output word |
| out_data | output | 16 | Output word |
| halted | output | 1 | Core has stopped |

## Verification
The core shows its internal state only through the output stream and the `halted` flag. A wrong accumulator therefore becomes visible at the next store-then-output pair, about ten cycles later. The test programs place that pair directly after every arithmetic step. A corrupt program counter or a mistaken jump decision changes the order or number of output words, or makes the core halt too early or too late. The jump tests therefore put distinct marker words on each path. Handshake faults show within one cycle, because the bench holds back `in_valid` and `out_ready` for several cycles and watches `in_ready`, `out_valid` and `out_data` during the stall.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_HLT  = 4'd0,
    OP_CLA  = 4'd1,
    OP_STO  = 4'd2,
    OP_ADD  = 4'd3,
    OP_SUB  = 4'd4,
    OP_MUL  = 4'd5,
    OP_DIV  = 4'd6,
    OP_JMP  = 4'd7,
    OP_JNEG = 4'd8,
    OP_JZER = 4'd9,
    OP_IN   = 4'd10,
    OP_OUT  = 4'd11,
    OP_SHR  = 4'd12,
    OP_COM  = 4'd13,
    OP_XOR  = 4'd14,
    OP_BAD  = 4'd15
  } op_e;

  typedef enum logic [2:0] {
    S_FETCH,
    S_LDIR,
    S_DECODE,
    S_EXEC,
    S_READ,
    S_PRINT,
    S_HALT
  } state_e;

endpackage

// File: rtl/acc_core_mem.sv
module acc_core_mem #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          re,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [0:DEPTH-1];

  // Single port, read-first; the read data register has no reset.
  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    if (re) rdata <= store[addr];
  end

endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
  import acc_core_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  always_comb begin
    unique case (op)
      OP_CLA:  y = b;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = a * b;
      OP_DIV:  y = (b == '0) ? '1 : (a / b);
      OP_XOR:  y = a ^ b;
      OP_SHR:  y = a >> 1;
      OP_COM:  y = ~a;
      default: y = a;
    endcase
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [DW-1:0] pre_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          halted
);

  // reset synchroniser: asserts at once, releases on a clock edge
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  // architectural and control state
  state_e        state_q, state_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [DW-1:0] ir_q, ir_d;
  logic [DW-1:0] acc_q, acc_d;
  logic [DW-1:0] mdr_q, mdr_d;

  // memory port
  logic          fsm_re, fsm_we;
  logic [AW-1:0] fsm_addr;
  logic [DW-1:0] fsm_wdata;
  logic          mem_re, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  op_e           ir_op;
  logic [AW-1:0] ir_addr;
  logic [DW-1:0] alu_y;

  assign ir_op   = op_e'(ir_q[DW-1 -: OP_W]);
  assign ir_addr = ir_q[AW-1:0];

  acc_core_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .re    (mem_re),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  acc_core_alu #(.DW(DW)) u_alu (
    .op (ir_op),
    .a  (acc_q),
    .b  (mem_rdata),
    .y  (alu_y)
  );

  // preload owns the memory port only while the core is in reset
  always_comb begin
    if (!rst_sync_n) begin
      mem_re    = 1'b0;
      mem_we    = pre_we;
      mem_addr  = pre_addr;
      mem_wdata = pre_data;
    end else begin
      mem_re    = fsm_re;
      mem_we    = fsm_we;
      mem_addr  = fsm_addr;
      mem_wdata = fsm_wdata;
    end
  end

  // next-state logic
  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    ir_d      = ir_q;
    acc_d     = acc_q;
    mdr_d     = mdr_q;
    fsm_re    = 1'b0;
    fsm_we    = 1'b0;
    fsm_addr  = ir_addr;
    fsm_wdata = acc_q;

    unique case (state_q)
      S_FETCH: begin
        fsm_re   = 1'b1;
        fsm_addr = pc_q;
        state_d  = S_LDIR;
      end
      S_LDIR: begin
        ir_d    = mem_rdata;
        pc_d    = pc_q + 1'b1;
        state_d = S_DECODE;
      end
      S_DECODE: begin
        fsm_re  = 1'b1;
        state_d = S_FETCH;
        unique case (ir_op)
          OP_HLT, OP_BAD: state_d = S_HALT;
          OP_STO: begin
            fsm_re = 1'b0;
            fsm_we = 1'b1;
          end
          OP_JMP:  pc_d = ir_addr;
          OP_JNEG: if (acc_q[DW-1]) pc_d = ir_addr;
          OP_JZER: if (acc_q == '0) pc_d = ir_addr;
          OP_SHR, OP_COM: acc_d = alu_y;
          OP_IN: begin
            fsm_re  = 1'b0;
            state_d = S_READ;
          end
          default: state_d = S_EXEC;
        endcase
      end
      S_EXEC: begin
        mdr_d   = mem_rdata;
        state_d = S_FETCH;
        if (ir_op == OP_OUT) state_d = S_PRINT;
        else                 acc_d   = alu_y;
      end
      S_READ: begin
        fsm_wdata = in_data;
        if (in_valid) begin
          fsm_we  = 1'b1;
          state_d = S_FETCH;
        end
      end
      S_PRINT: begin
        if (out_ready) state_d = S_FETCH;
      end
      default: state_d = S_HALT;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= S_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      mdr_q   <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ir_q    <= ir_d;
      acc_q   <= acc_d;
      mdr_q   <= mdr_d;
    end
  end

  assign in_ready  = (state_q == S_READ);
  assign out_valid = (state_q == S_PRINT);
  assign out_data  = mdr_q;
  assign halted    = (state_q == S_HALT);

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_core_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halted,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [AW-1:0] pc,
  input state_e        st
);

  // R11: stopping is permanent until reset
  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R11: a stopped core offers and accepts nothing
  a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!in_ready && !out_valid));

  // R10: offered output word held until taken
  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10: never both stream directions at once
  a_r10_one_stream: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R9: input wait persists until a word arrives
  a_r9_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

  // R2: program counter steps by one when the fetched word is captured
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LDIR) |=> (pc == AW'($past(pc) + 1'b1)));

endmodule

bind acc_core acc_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .halted    (halted),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .pc        (pc_q),
  .st        (state_q)
);

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pre_we = 1'b0;
  logic [11:0] pre_addr = '0;
  logic [15:0] pre_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic        halted;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  logic [15:0] got [0:31];
  logic [15:0] exp_w [0:31];
  int ngot = 0;

  always #4 clk = ~clk;  // 125 MHz

  acc_core u0 (
    .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_data(pre_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .halted(halted)
  );

  // record every accepted output word
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && ngot < 32) begin
      got[ngot] = out_data;
      ngot++;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  function automatic logic [15:0] ins(input int op, input int a);
    return {op[3:0], a[11:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [15:0] w);
    pre_we = 1'b1; pre_addr = a[11:0]; pre_data = w;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_run();
    ngot = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_halt(input string tag);
    int n = 0;
    while (!halted && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(halted, tag, {15'd0, halted}, 16'd1);
  endtask

  task automatic check_prints(input string tag, input int n);
    chk(ngot == n, tag, 16'(ngot), 16'(n));
    for (int i = 0; i < n && i < ngot; i++)
      chk(got[i] == exp_w[i], tag, got[i], exp_w[i]);
  endtask

  // R1: quiet outputs during reset
  task automatic t_reset();
    enter_reset();
    chk(!halted, "R1 halted in reset", {15'd0, halted}, 16'd0);
    chk(!in_ready, "R1 in_ready in reset", {15'd0, in_ready}, 16'd0);
    chk(!out_valid, "R1 out_valid in reset", {15'd0, out_valid}, 16'd0);
  endtask

  // R2 R3 R4 R5 R7: basic arithmetic chain
  task automatic t_arith();
    logic [15:0] a;
    enter_reset();
    put(64, 16'd1234); put(65, 16'd256); put(66, 16'd7);
    put(0, ins(1, 64));  put(1, ins(3, 65));  put(2, ins(2, 80));  put(3, ins(11, 80));
    put(4, ins(4, 66));  put(5, ins(2, 81));  put(6, ins(11, 81));
    put(7, ins(5, 66));  put(8, ins(2, 82));  put(9, ins(11, 82));
    put(10, ins(6, 66)); put(11, ins(2, 83)); put(12, ins(11, 83));
    put(13, ins(14, 64)); put(14, ins(2, 84)); put(15, ins(11, 84));
    put(16, ins(0, 0));
    chk(!halted && !out_valid, "R1 quiet after preload", {15'd0, halted}, 16'd0);
    a = 16'd1234 + 16'd256;  exp_w[0] = a;
    a = a - 16'd7;           exp_w[1] = a;
    a = a * 16'd7;           exp_w[2] = a;
    a = a / 16'd7;           exp_w[3] = a;
    a = a ^ 16'd1234;        exp_w[4] = a;
    release_run();
    wait_halt("R11 arith halts");
    check_prints("R4 R5 R7 arith results", 5);
  endtask

  // R4 R5 R6: wrap, divide by zero, shift and complement
  task automatic t_wrap();
    enter_reset();
    put(64, 16'hFFFF); put(65, 16'd2); put(66, 16'h8001); put(67, 16'h0300);
    put(68, 16'd0); put(69, 16'd100); put(70, 16'd7);
    put(0, ins(1, 64));  put(1, ins(3, 65));  put(2, ins(2, 80));  put(3, ins(11, 80));
    put(4, ins(1, 66));  put(5, ins(5, 67));  put(6, ins(2, 81));  put(7, ins(11, 81));
    put(8, ins(6, 68));  put(9, ins(2, 82));  put(10, ins(11, 82));
    put(11, ins(12, 12'h3FF)); put(12, ins(2, 83)); put(13, ins(11, 83));
    put(14, ins(13, 12'h123)); put(15, ins(2, 84)); put(16, ins(11, 84));
    put(17, ins(1, 69)); put(18, ins(6, 70)); put(19, ins(2, 85)); put(20, ins(11, 85));
    put(21, ins(4, 69)); put(22, ins(2, 86)); put(23, ins(11, 86));
    put(24, ins(0, 0));
    exp_w[0] = 16'h0001;                        // R4 add wraps
    exp_w[1] = 16'((32'h8001 * 32'h0300));      // R4 low half of product
    exp_w[2] = 16'hFFFF;                        // R5 zero divisor
    exp_w[3] = 16'h7FFF;                        // R6 logical shift
    exp_w[4] = 16'h8000;                        // R6 complement
    exp_w[5] = 16'd14;                          // R5 quotient 100/7
    exp_w[6] = 16'd14 - 16'd100;                // R4 subtract wraps
    release_run();
    wait_halt("R11 wrap halts");
    check_prints("R4 R5 R6 corner results", 7);
  endtask

  // R8: loop with zero test, sign test both ways
  task automatic t_jumps();
    enter_reset();
    put(64, 16'd3); put(65, 16'd1); put(66, 16'h8000); put(67, 16'hDEAD);
    put(68, 16'h0BEE); put(69, 16'h0C0C); put(70, 16'h0D0D);
    put(0, ins(1, 64)); put(1, ins(4, 65)); put(2, ins(2, 64)); put(3, ins(11, 64));
    put(4, ins(9, 6));  put(5, ins(7, 1));  put(6, ins(1, 66)); put(7, ins(8, 9));
    put(8, ins(11, 67)); put(9, ins(11, 68)); put(10, ins(1, 65)); put(11, ins(9, 13));
    put(12, ins(11, 69)); put(13, ins(8, 15)); put(14, ins(11, 70)); put(15, ins(0, 0));
    exp_w[0] = 16'd2; exp_w[1] = 16'd1; exp_w[2] = 16'd0;
    exp_w[3] = 16'h0BEE; exp_w[4] = 16'h0C0C; exp_w[5] = 16'h0D0D;
    release_run();
    wait_halt("R11 jumps halt");
    check_prints("R8 jump paths", 6);
  endtask

  task automatic feed(input logic [15:0] w, input int delay, input string tag);
    int n = 0;
    while (!in_ready && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(in_ready, tag, {15'd0, in_ready}, 16'd1);
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      chk(in_ready && !halted, {tag, " stall"}, {15'd0, in_ready}, 16'd1);
    end
    in_valid = 1'b1; in_data = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // R7 R9 R10 R12: compare two input words, print under back-pressure
  task automatic t_io(input logic [15:0] w1, input logic [15:0] w2, input bit same);
    logic [15:0] held;
    int n;
    enter_reset();
    put(0, ins(10, 90)); put(1, ins(10, 91)); put(2, ins(1, 90)); put(3, ins(14, 91));
    put(4, ins(9, 6));   put(5, ins(0, 0));   put(6, ins(11, 90)); put(7, ins(0, 0));
    out_ready = 1'b0;
    release_run();
    // R12: preload attempt while running must not replace the word at address 2
    n = 0;
    while (!in_ready && n < 200) begin
      @(negedge clk);
      n++;
    end
    put(2, 16'h0000);
    feed(w1, 4, "R9 first input");
    feed(w2, 0, "R9 second input");
    if (same) begin
      n = 0;
      while (!out_valid && n < 200) begin
        @(negedge clk);
        n++;
      end
      chk(out_valid, "R12 R7 output reached", {15'd0, out_valid}, 16'd1);
      held = out_data;
      chk(held == w1, "R9 stored word printed", held, w1);
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(out_valid && out_data == held, "R10 hold under back-pressure", out_data, held);
      end
      out_ready = 1'b1;
      wait_halt("R11 io halts");
      exp_w[0] = w1;
      check_prints("R10 one word delivered", 1);
    end else begin
      out_ready = 1'b1;
      wait_halt("R11 unequal halts");
      chk(ngot == 0, "R7 unequal words not reported", 16'(ngot), 16'd0);
    end
  endtask

  // R11: undefined code 15 stops the core for good
  task automatic t_illegal();
    enter_reset();
    put(64, 16'h1111); put(65, 16'h2222);
    put(0, ins(11, 64)); put(1, 16'hF000); put(2, ins(11, 65)); put(3, ins(0, 0));
    release_run();
    wait_halt("R11 code 15 halts");
    repeat (10) @(negedge clk);
    chk(halted && !out_valid && !in_ready, "R11 stays halted and quiet",
        {15'd0, halted}, 16'd1);
    exp_w[0] = 16'h1111;
    check_prints("R11 nothing after code 15", 1);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_wrap();
    t_jumps();
    t_io(16'h5A5A, 16'h5A5A, 1'b1);
    t_io(16'h5A5A, 16'h5A5B, 1'b0);
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule